// File: doc/BRIEF.md
# Opmask Register Add Unit

This block holds a small file of 64-bit mask registers and executes one instruction on them: the addition of two mask registers into a third. It receives an instruction whose fields have already been split out by an earlier stage: opcode byte, map select, the length bit, the width bit, the prefix field, the first-source register field and the ModRM byte. From these fields it picks an add width of 8, 16, 32 or 64 bits, adds the two sources at that width, and writes the sum into the destination. Every destination bit above the chosen width is cleared.

When the encoding is not a legal form of the instruction, the block raises an illegal-instruction flag in the same cycle and leaves every register unchanged. A load port writes a register directly, so results from other units can enter the file. A read port shows any register without waiting for a clock edge. The add takes one clock: sources are read combinationally and the destination updates on the next rising edge.

Top module: `mask_add_unit`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, sets every mask register to zero.
- R2: When `loadEn` is high at a rising edge, register `loadIdx` takes `loadData`.
- R3: `readData` always shows register `readIdx`, combinationally, with no clock edge needed.
- R4: An encoding is legal when all of the following hold: opcode is 0x4A, `mapSel` is 1 (the 0F map), `vexL` is 1, ModRM[7:6] is 11b, and `vexPp` is 00 or 01. The destination index is ModRM[5:3]. The first source is `vexVvvv[2:0]`, given in true (not inverted) form, and `vexVvvv[3]` is ignored. The second source is ModRM[2:0].
- R5: With `vexPp`=00 and `vexW`=0, the add is 16 bits wide.
- R6: With `vexPp`=00 and `vexW`=1, the add is 64 bits wide, and the carry out of bit 63 is dropped.
- R7: With `vexPp`=01 and `vexW`=0, the add is 8 bits wide.
- R8: With `vexPp`=01 and `vexW`=1, the add is 32 bits wide.
- R9: The sum is truncated to the selected width. Every destination bit above that width is written as zero.
- R10: When `valid` is high and the encoding is not legal, `illegal` is high in that same cycle and no register changes at the next edge.
- R11: When `valid` is low, `illegal` is low and the add writes nothing.
- R12: The sources are the values held before the edge, so the destination may be the same register as either source, or as both.
- R13: When an add and a load hit the same register in one cycle, the add result is written. When they hit different registers, both are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Opcode byte |
| mapSel | input | 5 | Opcode map select (1 = 0F map) |
| vexL | input | 1 | Vector length bit |
| vexW | input | 1 | Width bit |
| vexPp | input | 2 | Implied prefix field |
| vexVvvv | input | 4 | First-source register field, true form |
| modrm | input | 8 | ModRM byte |
| loadEn | input | 1 | Direct register load strobe |
| loadIdx | input | 3 | Register written by the load |
| loadData | input | 64 | Value written by the load |
| readIdx | input | 3 | Register shown on the read port |
| readData | output | 64 | Contents of register readIdx |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
An add and a direct load can target the same register in one cycle. The bench provokes this by driving a legal add and a load to the same destination together, and it expects the add result to win. A second cycle sends the add and the load to different registers, and the bench expects both writes to land. In both cases all eight registers are read back through the read port after the edge and compared against a bench model, so a lost write or a stray write is caught.

// File: rtl/mask_add_pkg.sv
package mask_add_pkg;

  typedef enum logic [1:0] {
    WID8  = 2'd0,
    WID16 = 2'd1,
    WID32 = 2'd2,
    WID64 = 2'd3
  } addWidth_e;

  localparam logic [7:0] OPC_MASK_ADD = 8'h4A;
  localparam logic [4:0] MAP_0F       = 5'd1;

  typedef struct packed {
    logic      addWr;
    logic      loadWr;
    addWidth_e width;
  } maskCtl_t;

endpackage

// File: rtl/mask_add_ctrl.sv
module mask_add_ctrl
  import mask_add_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [7:0]       opcode,
  input  logic [4:0]       mapSel,
  input  logic             vexL,
  input  logic             vexW,
  input  logic [1:0]       vexPp,
  input  logic [3:0]       vexVvvv,
  input  logic [7:0]       modrm,
  input  logic             loadEn,
  output maskCtl_t         ctl,
  output logic [IDX_W-1:0] dstIdx,
  output logic [IDX_W-1:0] src1Idx,
  output logic [IDX_W-1:0] src2Idx,
  output logic             illegal
);

  logic [2:0] regField;
  logic [2:0] rmField;
  logic [2:0] vField;
  logic       encLegal;
  logic       unusedVvvvTop;

  assign regField      = modrm[5:3];
  assign rmField       = modrm[2:0];
  assign vField        = vexVvvv[2:0];
  assign unusedVvvvTop = vexVvvv[3];

  assign dstIdx  = regField[IDX_W-1:0];
  assign src1Idx = vField[IDX_W-1:0];
  assign src2Idx = rmField[IDX_W-1:0];

  always_comb begin
    encLegal = (opcode == OPC_MASK_ADD) && (mapSel == MAP_0F) && vexL &&
               (modrm[7:6] == 2'b11) && !vexPp[1];
  end

  assign illegal = valid && !encLegal;

  always_comb begin
    ctl.addWr  = valid && encLegal;
    ctl.loadWr = loadEn;
    unique case ({vexPp[0], vexW})
      2'b00:   ctl.width = WID16;
      2'b01:   ctl.width = WID64;
      2'b10:   ctl.width = WID8;
      default: ctl.width = WID32;
    endcase
  end

  // R10
  bad_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && opcode != OPC_MASK_ADD) |-> (illegal && !ctl.addWr));

  // R10
  reserved_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && vexPp[1]) |-> (illegal && !ctl.addWr));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (!illegal && !ctl.addWr));

endmodule

// File: rtl/mask_add_datapath.sv
module mask_add_datapath
  import mask_add_pkg::*;
#(
  parameter int MASK_W   = 64,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  maskCtl_t          ctl,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [IDX_W-1:0]  src1Idx,
  input  logic [IDX_W-1:0]  src2Idx,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [MASK_W-1:0] loadData,
  input  logic [IDX_W-1:0]  readIdx,
  output logic [MASK_W-1:0] readData
);

  localparam int LANE_W = MASK_W / 8;
  localparam int LANES  = MASK_W / LANE_W;
  localparam int LC_W   = $clog2(LANES) + 1;

  logic [MASK_W-1:0] regs [NUM_REGS];
  logic [MASK_W-1:0] src1Data;
  logic [MASK_W-1:0] src2Data;
  logic [MASK_W-1:0] fullSum;
  logic [MASK_W-1:0] keepMask;
  logic [MASK_W-1:0] result;
  logic [LC_W-1:0]   laneCount;
  logic [LANE_W-1:0] lowSum;

  assign src1Data  = regs[src1Idx];
  assign src2Data  = regs[src2Idx];
  assign fullSum   = src1Data + src2Data;
  assign laneCount = LC_W'(1) << ctl.width;
  assign lowSum    = src1Data[LANE_W-1:0] + src2Data[LANE_W-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [LC_W-1:0] LANE_NUM = LC_W'(k);
    assign keepMask[k*LANE_W +: LANE_W] = {LANE_W{laneCount > LANE_NUM}};
  end

  assign result = fullSum & keepMask;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (ctl.addWr && dstIdx == IDX_W'(i)) begin
        regs[i] <= result;
      end else if (ctl.loadWr && loadIdx == IDX_W'(i)) begin
        regs[i] <= loadData;
      end
    end
  end

  assign readData = regs[readIdx];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    // R1
    reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (regs[i] == '0));

    // R4
    low_lane_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl.addWr && dstIdx == IDX_W'(i)) |=> (regs[i][LANE_W-1:0] == $past(lowSum)));

    // R9
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl.addWr && dstIdx == IDX_W'(i) && ctl.width == WID8)
      |=> (regs[i][MASK_W-1:LANE_W] == '0));

    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!(ctl.addWr && dstIdx == IDX_W'(i)) && !(ctl.loadWr && loadIdx == IDX_W'(i)))
      |=> $stable(regs[i]));
  end

endmodule

// File: rtl/mask_add_unit.sv
module mask_add_unit
  import mask_add_pkg::*;
#(
  parameter int MASK_W   = 64,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [7:0]        opcode,
  input  logic [4:0]        mapSel,
  input  logic              vexL,
  input  logic              vexW,
  input  logic [1:0]        vexPp,
  input  logic [3:0]        vexVvvv,
  input  logic [7:0]        modrm,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [MASK_W-1:0] loadData,
  input  logic [IDX_W-1:0]  readIdx,
  output logic [MASK_W-1:0] readData,
  output logic              illegal
);

  maskCtl_t         ctl;
  logic [IDX_W-1:0] dstIdx;
  logic [IDX_W-1:0] src1Idx;
  logic [IDX_W-1:0] src2Idx;

  mask_add_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid),
    .opcode  (opcode),
    .mapSel  (mapSel),
    .vexL    (vexL),
    .vexW    (vexW),
    .vexPp   (vexPp),
    .vexVvvv (vexVvvv),
    .modrm   (modrm),
    .loadEn  (loadEn),
    .ctl     (ctl),
    .dstIdx  (dstIdx),
    .src1Idx (src1Idx),
    .src2Idx (src2Idx),
    .illegal (illegal)
  );

  mask_add_datapath #(
    .MASK_W  (MASK_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .dstIdx  (dstIdx),
    .src1Idx (src1Idx),
    .src2Idx (src2Idx),
    .loadIdx (loadIdx),
    .loadData(loadData),
    .readIdx (readIdx),
    .readData(readData)
  );

endmodule

// File: tb/mask_add_unit_bench.sv
`timescale 1ns/1ps
module mask_add_unit_bench;

  typedef struct packed {
    logic       vld;
    logic [7:0] opc;
    logic [4:0] map;
    logic       l;
    logic       w;
    logic [1:0] pp;
    logic [3:0] vvvv;
    logic [7:0] modrm;
    logic       expIll;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b0, 2'b00, 4'h1, 8'hD3, 1'b0},
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b1, 2'b00, 4'h0, 8'hE9, 1'b0},
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b0, 2'b01, 4'h3, 8'hF4, 1'b0},
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b1, 2'b01, 4'hC, 8'hFB, 1'b0},
    '{1'b1, 8'h4A, 5'd1, 1'b0, 1'b0, 2'b00, 4'h1, 8'hD3, 1'b1},
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b0, 2'b00, 4'h1, 8'h53, 1'b1},
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b0, 2'b10, 4'h1, 8'hD3, 1'b1},
    '{1'b1, 8'h4B, 5'd1, 1'b1, 1'b0, 2'b00, 4'h1, 8'hD3, 1'b1},
    '{1'b1, 8'h4A, 5'd2, 1'b1, 1'b0, 2'b00, 4'h1, 8'hD3, 1'b1},
    '{1'b0, 8'h4A, 5'd1, 1'b1, 1'b0, 2'b00, 4'h1, 8'hC0, 1'b0},
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b1, 2'b01, 4'h2, 8'hC8, 1'b0},
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b0, 2'b01, 4'h7, 8'h3F, 1'b1},
    '{1'b1, 8'h4A, 5'd1, 1'b1, 1'b1, 2'b11, 4'h0, 8'hC0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst, valid, vexL, vexW, loadEn, illegal;
  logic [7:0]  opcode, modrm;
  logic [4:0]  mapSel;
  logic [1:0]  vexPp;
  logic [3:0]  vexVvvv;
  logic [2:0]  loadIdx, readIdx;
  logic [63:0] loadData, readData;
  logic [63:0] model [8];
  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  mask_add_unit u_mask_add_unit (
    .clk(clk), .rst(rst), .valid(valid), .opcode(opcode), .mapSel(mapSel),
    .vexL(vexL), .vexW(vexW), .vexPp(vexPp), .vexVvvv(vexVvvv), .modrm(modrm),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .readIdx(readIdx), .readData(readData), .illegal(illegal)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < 8; i++) begin
      readIdx = 3'(i);
      #0.2;
      check(tag, $sformatf("reg %0d", i), readData, model[i]);
    end
  endtask

  function automatic logic [63:0] addModel(logic [1:0] pp, logic w, logic [63:0] a, logic [63:0] b);
    logic [63:0] s;
    int bits;
    s = a + b;
    bits = pp[0] ? (w ? 32 : 8) : (w ? 64 : 16);
    if (bits < 64) s = s & ((64'd1 << bits) - 64'd1);
    return s;
  endfunction

  function automatic string tagOf(vec_t v);
    if (!v.vld) return "R11";
    if (v.expIll) return "R10";
    case ({v.pp[0], v.w})
      2'b00:   return "R4 R5 R9";
      2'b01:   return "R4 R6 R9";
      2'b10:   return "R4 R7 R9";
      default: return "R4 R8 R9";
    endcase
  endfunction

  task automatic driveAdd(vec_t v);
    valid = v.vld; opcode = v.opc; mapSel = v.map; vexL = v.l; vexW = v.w;
    vexPp = v.pp; vexVvvv = v.vvvv; modrm = v.modrm;
  endtask

  task automatic idle();
    valid = 1'b0; loadEn = 1'b0;
  endtask

  task automatic issue(vec_t v);
    @(negedge clk);
    driveAdd(v);
    #0.5;
    check(tagOf(v), "illegal flag", {63'd0, illegal}, {63'd0, v.vld & v.expIll});
    @(posedge clk);
    #0.5;
    idle();
    if (v.vld && !v.expIll)
      model[v.modrm[5:3]] = addModel(v.pp, v.w, model[v.vvvv[2:0]], model[v.modrm[2:0]]);
    checkAll(tagOf(v));
  endtask

  task automatic loadReg(int idx, logic [63:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = 3'(idx); loadData = data;
    @(posedge clk);
    #0.5;
    loadEn = 1'b0;
    model[idx] = data;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #100000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst = 1'b1; idle(); opcode = 8'h00; mapSel = 5'd0; vexL = 1'b0; vexW = 1'b0;
    vexPp = 2'b00; vexVvvv = 4'h0; modrm = 8'h00; loadIdx = 3'd0; loadData = '0; readIdx = 3'd0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #0.5;
    rst = 1'b0;
    checkAll("R1");

    loadReg(0, 64'hFFFF_FFFF_FFFF_FFFF);
    loadReg(1, 64'h0000_0000_0000_0001);
    loadReg(2, 64'h8000_0000_8000_8080);
    loadReg(3, 64'h0123_4567_89AB_CDEF);
    loadReg(4, 64'hF0F0_F0F0_F0F0_F0F0);
    loadReg(5, 64'h7FFF_FFFF_FFFF_FFFF);
    loadReg(6, 64'hAAAA_AAAA_AAAA_AAAA);
    loadReg(7, 64'h5555_5555_5555_5555);
    checkAll("R2");

    // R3: read port follows readIdx with no clock edge
    @(negedge clk);
    readIdx = 3'd3; #0.3;
    check("R3", "read idx 3", readData, model[3]);
    readIdx = 3'd6; #0.3;
    check("R3", "read idx 6", readData, model[6]);

    for (int n = 0; n < NV; n++) issue(VECS[n]);

    // R12: destination equals both sources, 64-bit add of register 3 to itself
    issue('{1'b1, 8'h4A, 5'd1, 1'b1, 1'b1, 2'b00, 4'h3, 8'hDB, 1'b0});
    check("R12", "self add", model[3], 64'h0246_8ACF_1357_9BDE);

    // R13: add and load to the same register; the add wins
    @(negedge clk);
    driveAdd('{1'b1, 8'h4A, 5'd1, 1'b1, 1'b1, 2'b00, 4'h1, 8'hD3, 1'b0});
    loadEn = 1'b1; loadIdx = 3'd2; loadData = 64'hDEAD_BEEF_DEAD_BEEF;
    @(posedge clk);
    #0.5;
    idle();
    model[2] = addModel(2'b00, 1'b1, model[1], model[3]);
    checkAll("R13");

    // R13: add and load to different registers; both land
    @(negedge clk);
    driveAdd('{1'b1, 8'h4A, 5'd1, 1'b1, 1'b0, 2'b00, 4'h0, 8'hC8, 1'b0});
    loadEn = 1'b1; loadIdx = 3'd4; loadData = 64'h1357_9BDF_0246_8ACE;
    @(posedge clk);
    #0.5;
    idle();
    model[1] = addModel(2'b00, 1'b0, model[0], model[0]);
    model[4] = 64'h1357_9BDF_0246_8ACE;
    checkAll("R13");

    // R1: reset in the middle of a run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #0.5;
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    checkAll("R1");

    finishRun();
  end

endmodule